// File: doc/BRIEF.md
# BCD Calendar Clock with Shadowed Host Registers

This block keeps calendar time (seconds, minutes, hours, day of week, date, month, two-digit year) in packed BCD and advances it on a one-cycle 1 Hz tick. A host reaches it through eight byte-wide locations. The host never touches the running counters. It reads and writes a shadow copy, and that copy is normally refreshed from the counters on every tick.

A control byte at offset 0 lets the host stop the refresh so it can read a consistent multi-byte time, or stop it and load a new time that is copied into the counters when the load bit is cleared. The counters keep counting through either kind of halt. A small state machine sequences these modes. Its states are `ST_RUN` (shadow follows the counters), `ST_FREEZE` (read halt), `ST_LOAD` (host may write time bytes) and `ST_COMMIT` (a single cycle that copies the shadow into the counters).

Transitions:
- `ST_RUN` moves to `ST_LOAD` on a control write with WRITE=1, or to `ST_FREEZE` on a control write with READ=1 and WRITE=0.
- `ST_FREEZE` moves to `ST_LOAD` on a control write with WRITE=1, or to `ST_RUN` on a control write with READ=0.
- `ST_LOAD` moves to `ST_COMMIT` on a control write with WRITE=0.
- `ST_COMMIT` moves to `ST_FREEZE` when READ is set, and to `ST_RUN` otherwise.

Top module: `rtc_shadow_regs`

## Requirements
- R1: After reset the registers read: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00.
- R2: The offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. In the control byte, bit 7 is WRITE, bit 6 is READ and bits 5:0 hold calibration sign and magnitude. The whole control byte reads back as written.
- R3: In ST_RUN a tick advances the counters. The shadow bytes take the advanced value at that same clock edge, all bytes together.
- R4: BCD rollover works as follows. Seconds and minutes go 59 to 00 with a carry. Hours go 23 to 00 with a carry into day and date. Day of week goes 7 to 1. Month goes 12 to 01 with a carry. Year goes 99 to 00.
- R5: The last date of a month is 30 for months 04, 06, 09 and 11, 31 for the other non-February months, and 28 for February in a non-leap year. After the last date the date becomes 01 and the month advances.
- R6: A year whose BCD value is divisible by 4, including 00, gives February 29 days.
- R7: While READ=1 the shadow time bytes hold their values, and the counters keep advancing. After READ is cleared the shadow refreshes on the next tick.
- R8: A tick in the same cycle as the control write that sets READ still updates the shadow.
- R9: While WRITE=1, host writes to offsets 1 to 7 are stored. Clearing WRITE copies them into the counters one cycle later, and the next tick shows the loaded time plus one second.
- R10: Host writes to offsets 1 to 7 are ignored while WRITE=0.
- R11: Bits defined as zero read as zero: minutes bit 7, hours bit 6, day bits 7 and 5:3, date bits 7:6, month bits 7:5. Seconds bit 7 (STOP), hours bit 7 and day bit 6 are stored flags.
- R12: While the committed seconds bit 7 (STOP) is 1, ticks do not advance the time.
- R13: A control write with both WRITE and READ set enters ST_LOAD. When WRITE is then cleared with READ still set, the block commits and enters ST_FREEZE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, one write per cycle high |
| host_rdata | output | 8 | Shadow byte at host_addr (combinational) |

## Verification
A wrong carry in the counters stays hidden until the next tick. At that edge the shadow takes the advanced value, so a bad rollover shows up on a read one cycle after the tick that crosses the boundary. The bench therefore loads times just short of each boundary and ticks once.

A state machine stuck in the wrong state shows up as shadow bytes that move during a read halt. It also shows up as time-byte writes that are accepted or dropped wrongly, or as a commit that never reaches the counters. A lost commit appears only on the first tick after WRITE is cleared, so every load is followed by a tick and a read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_COUNT = 8;
    localparam int ADDR_W    = $clog2(REG_COUNT);
    localparam int DATA_W    = 8;
    localparam int TIME_REGS = REG_COUNT - 1;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FREEZE = 2'd1,
        ST_LOAD   = 2'd2,
        ST_COMMIT = 2'd3
    } host_state_e;

    // Packed so that seconds sit in the least significant byte (offset 1).
    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    // Writable bits per offset; the rest read as zero.
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        case (idx)
            2:       reg_mask = 8'h7F;
            3:       reg_mask = 8'hBF;
            4:       reg_mask = 8'h47;
            5:       reg_mask = 8'h3F;
            6:       reg_mask = 8'h1F;
            default: reg_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        reg_reset = (idx >= 4 && idx <= 6) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'h0};
        else                bcd_inc = v + 8'd1;
    endfunction

    // 10 = 2 (mod 4), so value mod 4 = (2*tens + units) mod 4.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] m;
        m = yr[1:0] + {yr[4], 1'b0};
        is_leap = (m == 2'd0);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon[4:0])
            5'h02:                      month_last = is_leap(yr) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: month_last = 8'h30;
            default:                    month_last = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_host_fsm.sv
module rtc_host_fsm
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic        w_write,
    input  logic        w_read,
    input  logic        ctrl_read_q,
    output host_state_e state,
    output logic        upd_en,
    output logic        time_wr_en,
    output logic        commit
);

    host_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctrl_we && w_write)     state_d = ST_LOAD;
                else if (ctrl_we && w_read) state_d = ST_FREEZE;
            end
            ST_FREEZE: begin
                if (ctrl_we && w_write)      state_d = ST_LOAD;
                else if (ctrl_we && !w_read) state_d = ST_RUN;
            end
            ST_LOAD: begin
                if (ctrl_we && !w_write) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (ctrl_we && w_write)                  state_d = ST_LOAD;
                else if (ctrl_we ? w_read : ctrl_read_q) state_d = ST_FREEZE;
                else                                     state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        upd_en     = 1'b0;
        time_wr_en = 1'b0;
        commit     = 1'b0;
        unique case (state_q)
            ST_RUN:    upd_en     = 1'b1;
            ST_FREEZE: ;
            ST_LOAD:   time_wr_en = 1'b1;
            ST_COMMIT: commit     = 1'b1;
            default:   ;
        endcase
    end

    assign state = state_q;

    p_load_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_LOAD || state_q == ST_COMMIT));

    p_commit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q != ST_COMMIT));

    p_both_bits_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl_we && w_write && w_read) |=> (state_q == ST_LOAD));

endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cal_t ld_val,
    output cal_t cur,
    output cal_t nxt
);

    cal_t cur_q;
    logic [7:0] inc_sec, inc_min, inc_hr, inc_date, inc_mon, inc_yr;
    logic [7:0] last_date;
    logic       stopped;

    assign stopped   = cur_q.sec[7];
    assign inc_sec   = bcd_inc({1'b0, cur_q.sec[6:0]});
    assign inc_min   = bcd_inc({1'b0, cur_q.min[6:0]});
    assign inc_hr    = bcd_inc({2'b0, cur_q.hr[5:0]});
    assign inc_date  = bcd_inc({2'b0, cur_q.date[5:0]});
    assign inc_mon   = bcd_inc({3'b0, cur_q.mon[4:0]});
    assign inc_yr    = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
    assign last_date = month_last(cur_q.mon, cur_q.yr);

    // Carry chain: each field only moves when every lower field wraps.
    always_comb begin
        nxt = cur_q;
        if (!stopped) begin
            if (cur_q.sec[6:0] != 7'h59) begin
                nxt.sec[6:0] = inc_sec[6:0];
            end else begin
                nxt.sec[6:0] = 7'h00;
                if (cur_q.min[6:0] != 7'h59) begin
                    nxt.min[6:0] = inc_min[6:0];
                end else begin
                    nxt.min[6:0] = 7'h00;
                    if (cur_q.hr[5:0] != 6'h23) begin
                        nxt.hr[5:0] = inc_hr[5:0];
                    end else begin
                        nxt.hr[5:0]  = 6'h00;
                        nxt.day[2:0] = (cur_q.day[2:0] >= 3'd7) ? 3'd1 : cur_q.day[2:0] + 3'd1;
                        if ({2'b0, cur_q.date[5:0]} != last_date) begin
                            nxt.date[5:0] = inc_date[5:0];
                        end else begin
                            nxt.date[5:0] = 6'h01;
                            if (cur_q.mon[4:0] != 5'h12) begin
                                nxt.mon[4:0] = inc_mon[4:0];
                            end else begin
                                nxt.mon[4:0] = 5'h01;
                                nxt.yr       = inc_yr;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{yr: 8'h00, mon: 8'h01, date: 8'h01, day: 8'h01,
                       hr: 8'h00, min: 8'h00, sec: 8'h00};
        end else if (load) begin
            cur_q <= ld_val;
        end else if (tick) begin
            cur_q <= nxt;
        end
    end

    assign cur = cur_q;

    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !cur_q.sec[7] && cur_q.sec[6:0] == 7'h59)
        |=> (cur_q.sec[6:0] == 7'h00));

    p_stop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cur_q.sec[7]) |=> $stable(cur_q));

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    output logic [DATA_W-1:0] host_rdata
);

    logic [DATA_W-1:0] sreg_q [REG_COUNT];
    host_state_e state;
    logic upd_en, time_wr_en, commit, ctrl_we;
    cal_t cnt_cur, cnt_nxt, shd_cal;

    assign ctrl_we = host_we && (host_addr == '0);

    rtc_host_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .w_write     (host_wdata[7]),
        .w_read      (host_wdata[6]),
        .ctrl_read_q (sreg_q[0][6]),
        .state       (state),
        .upd_en      (upd_en),
        .time_wr_en  (time_wr_en),
        .commit      (commit)
    );

    assign shd_cal = {sreg_q[7], sreg_q[6], sreg_q[5], sreg_q[4],
                      sreg_q[3], sreg_q[2], sreg_q[1]};

    rtc_counters u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .load   (commit),
        .ld_val (shd_cal),
        .cur    (cnt_cur),
        .nxt    (cnt_nxt)
    );

    // Control register: always writable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sreg_q[0] <= reg_reset(0);
        else if (ctrl_we) sreg_q[0] <= host_wdata;
    end

    // Time registers: host load in ST_LOAD, refresh from counters in ST_RUN.
    for (genvar gi = 1; gi < REG_COUNT; gi++) begin : g_time
        localparam logic [DATA_W-1:0] MASK = reg_mask(gi);
        logic hit;
        assign hit = host_we && (host_addr == ADDR_W'(gi));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sreg_q[gi] <= reg_reset(gi);
            end else if (time_wr_en && hit) begin
                sreg_q[gi] <= host_wdata & MASK;
            end else if (upd_en && tick_1hz) begin
                sreg_q[gi] <= cnt_nxt[(gi-1)*DATA_W +: DATA_W] & MASK;
            end
        end
    end

    assign host_rdata = sreg_q[host_addr];

    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREEZE) |=> $stable(shd_cal));

    p_commit_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (cnt_cur == $past(shd_cal)));

    p_ignore_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick_1hz) |=> $stable(shd_cal));

    p_zero_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (shd_cal.min[7] == 1'b0 && shd_cal.hr[6] == 1'b0 && shd_cal.day[7] == 1'b0 &&
         shd_cal.day[5:3] == 3'b0 && shd_cal.date[7:6] == 2'b0 && shd_cal.mon[7:5] == 3'b0));

    p_run_refresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick_1hz && !host_we) |=> (shd_cal == cnt_cur));

endmodule

// File: tb/rtc_shadow_regs_bench.sv
module rtc_shadow_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    rtc_shadow_regs u_rtc_shadow_regs (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_we(host_we), .host_rdata(host_rdata)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    // Loads a full time through the WRITE handshake and waits for the commit.
    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(3'd0, 8'h80);
        wr(3'd1, s); wr(3'd2, m); wr(3'd3, h); wr(3'd4, dw);
        wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, y);
        wr(3'd0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 3'd0, 8'h00); rd_chk("R1 sec", 3'd1, 8'h00);
        rd_chk("R1 min", 3'd2, 8'h00); rd_chk("R1 hr", 3'd3, 8'h00);
        rd_chk("R1 day", 3'd4, 8'h01); rd_chk("R1 date", 3'd5, 8'h01);
        rd_chk("R1 month", 3'd6, 8'h01); rd_chk("R1 year", 3'd7, 8'h00);
    endtask

    task automatic t_basic_tick();
        tick(); tick(); tick();
        rd_chk("R3 sec after 3 ticks", 3'd1, 8'h03);
        wr(3'd0, 8'h2A);
        rd_chk("R2 ctrl readback", 3'd0, 8'h2A);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_rollover();
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick();
        rd_chk("R4 sec", 3'd1, 8'h00); rd_chk("R4 min", 3'd2, 8'h00);
        rd_chk("R4 hr", 3'd3, 8'h00); rd_chk("R4 day", 3'd4, 8'h01);
        rd_chk("R4 date", 3'd5, 8'h01); rd_chk("R4 month", 3'd6, 8'h01);
        rd_chk("R4 year", 3'd7, 8'h00);
        set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h14, 8'h03, 8'h41);
        tick();
        rd_chk("R3 hour carry", 3'd3, 8'h10);
        rd_chk("R3 min same edge", 3'd2, 8'h00);
    endtask

    task automatic t_month_len();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
        tick();
        rd_chk("R5 apr30 date", 3'd5, 8'h01); rd_chk("R5 apr30 month", 3'd6, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h05, 8'h23);
        tick();
        rd_chk("R5 may30 date", 3'd5, 8'h31);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        tick();
        rd_chk("R5 feb28 date", 3'd5, 8'h01); rd_chk("R5 feb28 month", 3'd6, 8'h03);
    endtask

    task automatic t_leap();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        tick();
        rd_chk("R6 year24 feb29", 3'd5, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        tick();
        rd_chk("R6 feb29 end", 3'd6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
        tick();
        rd_chk("R6 year00", 3'd5, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h12);
        tick();
        rd_chk("R6 year12", 3'd5, 8'h29);
    endtask

    task automatic t_read_freeze();
        set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h25);
        wr(3'd0, 8'h40);
        tick(); tick(); tick();
        rd_chk("R7 frozen sec", 3'd1, 8'h00);
        wr(3'd0, 8'h00);
        rd_chk("R7 stale until tick", 3'd1, 8'h00);
        tick();
        rd_chk("R7 refreshed sec", 3'd1, 8'h04);
    endtask

    task automatic t_read_same_cycle();
        set_time(8'h20, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h25);
        @(negedge clk);
        host_addr = 3'd0; host_wdata = 8'h40; host_we = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        host_we = 1'b0; tick_1hz = 1'b0;
        tick();
        rd_chk("R8 update finished", 3'd1, 8'h21);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_ignore_write();
        set_time(8'h05, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h25);
        wr(3'd1, 8'h45);
        rd_chk("R10 sec ignored", 3'd1, 8'h05);
        tick();
        rd_chk("R9 loaded plus one", 3'd1, 8'h06);
    endtask

    task automatic t_zero_bits();
        wr(3'd0, 8'h80);
        wr(3'd2, 8'hD9); wr(3'd3, 8'hE3); wr(3'd4, 8'hFD);
        wr(3'd5, 8'hF2); wr(3'd6, 8'hE9);
        rd_chk("R11 min", 3'd2, 8'h59); rd_chk("R11 hr", 3'd3, 8'hA3);
        rd_chk("R11 day", 3'd4, 8'h45); rd_chk("R11 date", 3'd5, 8'h32);
        rd_chk("R11 month", 3'd6, 8'h09);
        wr(3'd0, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_stop();
        set_time(8'h90, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h25);
        tick(); tick();
        rd_chk("R12 stopped", 3'd1, 8'h90);
        set_time(8'h10, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h25);
        tick();
        rd_chk("R12 running", 3'd1, 8'h11);
    endtask

    task automatic t_priority();
        set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h25);
        wr(3'd0, 8'hC0);
        wr(3'd1, 8'h33);
        rd_chk("R13 load accepted", 3'd1, 8'h33);
        wr(3'd0, 8'h40);
        @(negedge clk);
        tick();
        rd_chk("R13 frozen after commit", 3'd1, 8'h33);
        rd_chk("R13 ctrl", 3'd0, 8'h40);
        wr(3'd0, 8'h00);
        tick();
        rd_chk("R13 counters kept running", 3'd1, 8'h35);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_basic_tick();
                t_rollover();
                t_month_len();
                t_leap();
                t_read_freeze();
                t_read_same_cycle();
                t_ignore_write();
                t_zero_bits();
                t_stop();
                t_priority();
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule